// File: doc/BRIEF.md
# Dual Counter/Timer with Split Low/High Mode

This block holds two 16-bit counter/timers, Timer 0 and Timer 1, each built from a low and a high byte. Each timer can run as a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads from its high byte. Software sets the mode, the run bits, the gating and the count source through a small byte-wide register file. Software watches the two sticky overflow flags, which hold until software clears them.

Mode 3 on Timer 0 splits it into two free 8-bit counters. The low byte keeps Timer 0's run bit, gate and flag. The high byte becomes a plain timer that takes over Timer 1's run bit and overflow flag. Timer 1 keeps counting in the background while Timer 0 is split. Its overflow then reaches the outside only as a one-cycle strobe, which can drive a baud-rate generator or start a converter.

Counting advances only on single-cycle enable ticks: the system tick, the prescaled tick, or a falling edge on a synchronized external input. The block never derives a clock.

Top module: `dual_timer_split`

## Requirements
- R1: After reset, every register reads zero, both flags are low and the strobe is low.
- R2: The mode register (address 1) holds, from bit 7 down to bit 0: gate1, count-select1, mode1[1:0], gate0, count-select0, mode0[1:0]. In mode 0 a timer is a 13-bit counter formed by the high byte over low-byte bits 4:0. Low-byte bits 7:5 are left unchanged.
- R3: In mode 1 a timer is a 16-bit counter. Its overflow sets its flag. The control register (address 0) has run0 at bit 0, flag0 at bit 1, run1 at bit 2 and flag1 at bit 3.
- R4: In mode 2 the low byte counts. When it overflows it reloads from the high byte and sets the flag.
- R5: With count-select 0, a timer counts the system tick, or the prescaled tick when its config bit is set. Config is at address 2: bit 0 selects the prescaled tick for Timer 0, bit 1 for Timer 1, and bit 2 for the split high byte. With count-select 1, the timer counts only falling edges of its external input after synchronization.
- R6: With the gate bit set, a timer counts only while its run bit is 1 and its interrupt pin XOR its polarity bit is 1. The polarity bits are config bits 3 (Timer 0) and 4 (Timer 1).
- R7: In split mode the low byte (address 3) is an 8-bit counter using run0, gate0, count-select0 and flag0. The high byte (address 4) is an 8-bit timer enabled by run1. Its overflow sets flag1.
- R8: While Timer 0 is split, Timer 1 counts only its timebase tick in modes 0, 1 and 2, ignoring run1, its gate and its external input. Mode 3 stops it. Its overflow never sets flag1.
- R9: Each Timer 1 overflow produces a one-cycle strobe, split or not. Outside split mode, Timer 1 in mode 3 holds its count.
- R10: A flag stays set until a control write puts 0 in its bit. An overflow in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_tick | input | 1 | System timebase enable tick |
| pre_tick | input | 1 | Prescaled timebase enable tick |
| t0_ext | input | 1 | Asynchronous external count input, Timer 0 |
| t1_ext | input | 1 | Asynchronous external count input, Timer 1 |
| int0_pin | input | 1 | Gate pin, Timer 0 |
| int1_pin | input | 1 | Gate pin, Timer 1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| flag0 | output | 1 | Timer 0 overflow flag |
| flag1 | output | 1 | Timer 1 overflow flag (split high byte in mode 3) |
| t1_ovf | output | 1 | One-cycle Timer 1 overflow strobe |

## Verification
The bench drives one table of per-mode preload and tick-count cases on Timer 0. These cases expose a mode 0 counter that clobbers low-byte bits 7:5 and a mode 2 counter that fails to reload, or that reloads one tick late. Directed cases then go after the split mode. A design that let Timer 1 set flag1, obey run1, or count its external pin while Timer 0 is split would show a wrong flag or count. So would a split high byte that ignores run1. Further cases cover an overflow that meets a clearing write, where a design with the wrong priority loses the flag. They also cover gating with both polarities and the external edge counter, where a level-sensitive or unsynchronized design counts the wrong number of events.

// File: rtl/dual_timer_split.sv
module dual_timer_split (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_tick,
  input  logic       pre_tick,
  input  logic       t0_ext,
  input  logic       t1_ext,
  input  logic       int0_pin,
  input  logic       int1_pin,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       flag0,
  output logic       flag1,
  output logic       t1_ovf
);
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_CFG = 3'd2,
                         A_LO0 = 3'd3, A_HI0 = 3'd4, A_LO1 = 3'd5, A_HI1 = 3'd6;

  logic [7:0] mode, lo0, hi0, lo1, hi1;
  logic [4:0] cfg;
  logic       run0, run1;
  logic [2:0] s_e0, s_e1;
  logic [1:0] s_i0, s_i1;

  // returns {overflow, next_hi, next_lo}
  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [13:0] c13;
    logic [16:0] c16;
    case (m)
      2'd0: begin
        c13 = {1'b0, hi, lo[4:0]} + 14'd1;
        return {c13[13], c13[12:5], lo[7:5], c13[4:0]};
      end
      2'd1: begin
        c16 = {1'b0, hi, lo} + 17'd1;
        return c16;
      end
      2'd2: return (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: return {lo == 8'hFF, hi, lo + 8'd1};
    endcase
  endfunction

  wire split  = mode[1:0] == 2'd3;
  wire fall0  = s_e0[2] & ~s_e0[1];
  wire fall1  = s_e1[2] & ~s_e1[1];

  wire gate0  = ~mode[3] | (s_i0[1] ^ cfg[3]);
  wire gate1  = ~mode[7] | (s_i1[1] ^ cfg[4]);
  wire base0  = cfg[0] ? pre_tick : sys_tick;
  wire base1  = cfg[1] ? pre_tick : sys_tick;
  wire baseh  = cfg[2] ? pre_tick : sys_tick;

  wire en0    = run0 & gate0 & (mode[2] ? fall0 : base0);
  wire tick1  = (mode[6] & ~split) ? fall1 : base1;
  wire go1    = split ? 1'b1 : (run1 & gate1);
  wire en1    = go1 & tick1 & (mode[5:4] != 2'd3);
  wire enh    = split & run1 & baseh;

  wire [16:0] nx0 = step(mode[1:0], lo0, hi0);
  wire [16:0] nx1 = step(mode[5:4], lo1, hi1);

  wire ev0    = en0 & nx0[16];
  wire ev1    = en1 & nx1[16];
  wire evh    = enh & (hi0 == 8'hFF);

  wire wr_ctl = wr_en & (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_e0 <= '0; s_e1 <= '0; s_i0 <= '0; s_i1 <= '0;
    end else begin
      s_e0 <= {s_e0[1:0], t0_ext};
      s_e1 <= {s_e1[1:0], t1_ext};
      s_i0 <= {s_i0[0], int0_pin};
      s_i1 <= {s_i1[0], int1_pin};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; cfg <= '0; run0 <= 1'b0; run1 <= 1'b0;
      flag0 <= 1'b0; flag1 <= 1'b0; t1_ovf <= 1'b0;
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
    end else begin
      t1_ovf <= ev1;
      flag0  <= ev0 | (wr_ctl ? wr_data[1] : flag0);
      flag1  <= (split ? evh : ev1) | (wr_ctl ? wr_data[3] : flag1);
      if (wr_ctl) begin
        run0 <= wr_data[0];
        run1 <= wr_data[2];
      end
      if (wr_en && addr == A_MODE) mode <= wr_data;
      if (wr_en && addr == A_CFG)  cfg  <= wr_data[4:0];

      if (wr_en && addr == A_LO0)  lo0 <= wr_data;
      else if (en0)                lo0 <= nx0[7:0];

      if (wr_en && addr == A_HI0)  hi0 <= wr_data;
      else if (enh)                hi0 <= hi0 + 8'd1;
      else if (en0 && !split)      hi0 <= nx0[15:8];

      if (wr_en && addr == A_LO1)  lo1 <= wr_data;
      else if (en1)                lo1 <= nx1[7:0];

      if (wr_en && addr == A_HI1)  hi1 <= wr_data;
      else if (en1)                hi1 <= nx1[15:8];
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {4'b0, flag1, run1, flag0, run0};
      A_MODE:  rd_data = mode;
      A_CFG:   rd_data = {3'b0, cfg};
      A_LO0:   rd_data = lo0;
      A_HI0:   rd_data = hi0;
      A_LO1:   rd_data = lo1;
      A_HI1:   rd_data = hi1;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module dual_timer_split_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wr_data,
  input logic       flag0,
  input logic       flag1,
  input logic       t1_ovf,
  input logic [7:0] mode,
  input logic       run0,
  input logic [7:0] lo0
);
  // R10
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag0) |-> $past(wr_en && addr == 3'd0 && !wr_data[1]));

  // R10
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag1) |-> $past(wr_en && addr == 3'd0 && !wr_data[3]));

  // R9
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_ovf |-> $past(mode[5:4]) != 2'd3);

  // R6
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !(wr_en && addr == 3'd3)) |=> $stable(lo0));
endmodule

bind dual_timer_split dual_timer_split_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .flag0(flag0), .flag1(flag1), .t1_ovf(t1_ovf), .mode(mode), .run0(run0), .lo0(lo0)
);

// File: tb/sim_dual_timer_split.sv
module sim_dual_timer_split;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_tick = 0, pre_tick = 0, t0_ext = 0, t1_ext = 0, int0_pin = 0, int1_pin = 0;
  logic wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic flag0, flag1, t1_ovf;
  int runs = 0, fails = 0, strobes = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_timer_split u0 (.clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .pre_tick(pre_tick),
    .t0_ext(t0_ext), .t1_ext(t1_ext), .int0_pin(int0_pin), .int1_pin(int1_pin),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .flag0(flag0), .flag1(flag1), .t1_ovf(t1_ovf));

  always @(posedge clk) if (rst_n && t1_ovf) strobes++;

  // {mode, lo, hi, ticks, exp_lo, exp_hi, exp_flag0}
  localparam logic [55:0] VEC [6] = '{
    {8'h01, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 8'h01},
    {8'h01, 8'hFF, 8'h12, 8'd1, 8'h00, 8'h13, 8'h00},
    {8'h00, 8'h1F, 8'h05, 8'd1, 8'h00, 8'h06, 8'h00},
    {8'h00, 8'hFF, 8'hFF, 8'd1, 8'hE0, 8'h00, 8'h01},
    {8'h02, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 8'h01},
    {8'h03, 8'hFF, 8'h10, 8'd1, 8'h00, 8'h10, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); sys_tick = 1;
    repeat (n) @(negedge clk);
    sys_tick = 0;
  endtask

  task automatic clear_all();
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int sc;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin rd(a[2:0], v); check("R1 reg", v, 8'h00); end
    check("R1 flags/strobe", {5'b0, flag0, flag1, t1_ovf}, 8'h00);
    rst_n = 1;

    // R2 R3 R4 R7 table
    for (int i = 0; i < 6; i++) begin
      clear_all();
      wr(1, VEC[i][55:48]); wr(3, VEC[i][47:40]); wr(4, VEC[i][39:32]);
      wr(0, 8'h01);
      ticks(int'(VEC[i][31:24]));
      rd(3, v); check("R2/R3/R4/R7 table lo", v, VEC[i][23:16]);
      rd(4, v); check("R2/R3/R4/R7 table hi", v, VEC[i][15:8]);
      check("R3/R4 table flag0", {7'b0, flag0}, VEC[i][7:0]);
    end

    // R6 gate with polarity
    clear_all(); wr(1, 8'h09); wr(3, 0); wr(4, 0); int0_pin = 0; wr(0, 8'h01);
    ticks(4); rd(3, v); check("R6 gate closed", v, 8'h00);
    int0_pin = 1; repeat (3) @(negedge clk);
    ticks(4); rd(3, v); check("R6 gate open", v, 8'h04);
    wr(2, 8'h08); repeat (3) @(negedge clk);
    ticks(4); rd(3, v); check("R6 inverted polarity blocks", v, 8'h04);
    int0_pin = 0;

    // R5 prescaled timebase
    clear_all(); wr(2, 8'h01); wr(1, 8'h01); wr(3, 0); wr(0, 8'h01);
    ticks(5); rd(3, v); check("R5 sys tick ignored", v, 8'h00);
    @(negedge clk); pre_tick = 1; repeat (2) @(negedge clk); pre_tick = 0;
    rd(3, v); check("R5 prescaled count", v, 8'h02);

    // R5 external falling edges
    clear_all(); wr(1, 8'h05); wr(3, 0); wr(0, 8'h01);
    ticks(3); rd(3, v); check("R5 ext mode ignores tick", v, 8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); t0_ext = 1; repeat (4) @(negedge clk); t0_ext = 0; repeat (4) @(negedge clk);
    end
    rd(3, v); check("R5 ext edges", v, 8'h03);

    // R7 split high byte on run1
    clear_all(); wr(1, 8'h03); wr(3, 0); wr(4, 8'hFF); wr(0, 8'h04);
    ticks(1);
    rd(4, v); check("R7 high wraps", v, 8'h00);
    rd(3, v); check("R7 low stopped", v, 8'h00);
    rd(0, v); check("R7 flag1 set", v, 8'h0C);

    // R8 R9 split: Timer 1 strobe but no flag
    clear_all(); wr(1, 8'h23); wr(5, 8'hFF); wr(6, 8'hAA);
    sc = strobes;
    ticks(1); repeat (2) @(negedge clk);
    rd(5, v); check("R8 split reload", v, 8'hAA);
    rd(0, v); check("R8 no flag1", v, 8'h00);
    check("R9 split strobe", 8'(strobes - sc), 8'h01);

    // R8 external input ignored in split
    wr(1, 8'h63); wr(5, 8'h10);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); t1_ext = 1; repeat (4) @(negedge clk); t1_ext = 0; repeat (4) @(negedge clk);
    end
    rd(5, v); check("R8 ext ignored", v, 8'h10);
    ticks(2); rd(5, v); check("R8 counts tick without run1", v, 8'h12);

    // R8 mode 3 stops Timer 1 in split
    wr(1, 8'h33); wr(5, 8'h10); ticks(3);
    rd(5, v); check("R8 mode3 stop", v, 8'h10);

    // R9 normal Timer 1 overflow
    clear_all(); wr(1, 8'h10); wr(5, 8'hFF); wr(6, 8'hFF); wr(0, 8'h04);
    sc = strobes;
    ticks(1); repeat (2) @(negedge clk);
    rd(0, v); check("R9 flag1 normal", v, 8'h0C);
    check("R9 strobe normal", 8'(strobes - sc), 8'h01);
    rd(6, v); check("R3 timer1 wrap", v, 8'h00);

    // R9 Timer 1 mode 3 holds outside split
    clear_all(); wr(1, 8'h30); wr(5, 8'h05); wr(0, 8'h04); ticks(2);
    rd(5, v); check("R9 mode3 hold", v, 8'h05);

    // R10 set beats clear
    clear_all(); wr(1, 8'h01); wr(3, 8'hFF); wr(4, 8'hFF); wr(0, 8'h01);
    @(negedge clk); sys_tick = 1; addr = 0; wr_data = 8'h01; wr_en = 1;
    @(negedge clk); sys_tick = 0; wr_en = 0;
    rd(0, v); check("R10 set wins", v, 8'h03);
    repeat (3) @(negedge clk);
    rd(0, v); check("R10 sticky", v, 8'h03);
    wr(0, 8'h00); rd(0, v); check("R10 cleared", v, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule